// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block sits in an SDRAM controller's command path. It keeps the part of the mode register that shapes bursts and, once a read or write column command is issued, produces the column address of every data beat. A mode-register load carries a 14-bit operand. Its two top bits select the target register, and only the value 00 addresses the burst mode register. From the low twelve bits the block takes the burst length, the burst type, the CAS latency and the single-beat write option.

A start pulse with an 8-bit column begins a burst. Depending on the burst type, the column walks upward with wrap-around inside the aligned burst block, or it is the start column XOR the beat index. A full-page burst steps through all columns and keeps going until it is stopped. A stop pulse ends any burst. A new start on any clock replaces the running burst. The settings in force when a burst starts are captured, so a later mode load does not change that burst.

Top module: `burst_colgen`

## Requirements
- R1: After reset, beat_valid, last_beat and mode_err are 0, cas_lat is 2, and the burst length is 1 with sequential order and no single-beat write.
- R2: A load with operand[13:12]=00 sets the burst length from operand[2:0]: 000 gives 1 beat, 001 gives 2, 010 gives 4, 011 gives 8, and 111 gives full page.
- R3: When operand[3]=0 (sequential), beat i has column start with its low log2(L) bits replaced by (start+i) mod L, where L is the burst length. For L=4 and a start of 1, the order is 1,2,3,0.
- R4: When operand[3]=1 (interleave), beat i has column start XOR i. For L=8 and a start of 5, the order is 5,4,7,6,1,0,3,2.
- R5: When operand[9]=1, a burst started with start_is_write=1 has exactly one beat, and reads keep the programmed length.
- R6: A full-page burst gives start, start+1, ... mod 256, wraps past 255, never raises last_beat, and runs until stopped or restarted.
- R7: If stop is sampled without start, beat_valid is 0 in the next cycle, whatever the burst length, including full page.
- R8: A start sampled on any edge makes the next cycle show beat 0 of the new burst at start_col. This holds during a running burst, and start wins over a stop in the same cycle.
- R9: A reserved burst-length code (100, 101 or 110) leaves the previous length in place and sets mode_err. The next load with a valid length code clears mode_err.
- R10: operand[6:4] sets cas_lat: 001 gives 1, 010 gives 2, 011 gives 3. Other codes leave cas_lat unchanged.
- R11: A load with operand[13:12] not equal to 00 changes nothing: not cas_lat, not mode_err, and not the length, type or write option of later bursts.
- R12: A mode load during a burst does not change the columns or the length of that burst.
- R13: last_beat is 1 exactly on the final beat of a burst that is not full page, and beat_valid is 0 in the following cycle unless a new start was sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_load | input | 1 | Mode register load strobe |
| mode_operand | input | 14 | Load operand: [13:12] register select, [11:0] fields |
| start | input | 1 | Column command: begin a burst |
| start_is_write | input | 1 | The column command is a write |
| start_col | input | 8 | Starting column of the burst |
| stop | input | 1 | Burst terminate |
| col | output | 8 | Column of the current beat |
| beat_valid | output | 1 | A beat is in progress this cycle |
| last_beat | output | 1 | This beat is the final one |
| cas_lat | output | 2 | Programmed CAS latency (1 to 3) |
| mode_err | output | 1 | The last accepted load had a reserved length code |

## Verification
A wrong captured base, length or type shows up on col within one cycle of the start, as a column the wrap or XOR rule does not allow. A wrong beat counter shows up as a wrong column, as last_beat on the wrong beat, or as beat_valid staying high too long. Mode-register faults show up only when the next burst starts, or on cas_lat and mode_err one cycle after the load. For that reason every load in the bench is followed by a burst that exposes it. A per-cycle reference model compares all outputs on every clock, so a fault is reported in the cycle it first appears.

// File: rtl/colgen_pkg.sv
package colgen_pkg;

  typedef enum logic {ORD_SEQ = 1'b0, ORD_XOR = 1'b1} beat_order_e;

  typedef struct packed {
    logic [1:0]  len_log;   // log2 of burst length for fixed bursts
    logic        full;      // full-page burst
    beat_order_e order;     // sequential or interleave
    logic        wr_single; // writes are one beat
  } burst_cfg_t;

  // Burst-length code validity: 0..3 fixed, 7 full page.
  function automatic logic len_code_ok(input logic [2:0] code);
    return (code[2] == 1'b0) || (code == 3'b111);
  endfunction

  function automatic logic lat_code_ok(input logic [2:0] code);
    return (code != 3'b000) && (code[2] == 1'b0);
  endfunction

endpackage

// File: rtl/colgen_modereg.sv
module colgen_modereg
  import colgen_pkg::*;
#(
  parameter int OP_W = 14
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [OP_W-1:0] operand,
  output burst_cfg_t      cfg,
  output logic [1:0]      cas_lat,
  output logic            mode_err,
  output logic            load_accept
);

  localparam int SEL_HI = OP_W - 1;
  localparam int SEL_LO = OP_W - 2;

  logic [2:0] len_code;
  logic [2:0] lat_code;

  assign len_code    = operand[2:0];
  assign lat_code    = operand[6:4];
  assign load_accept = load && (operand[SEL_HI:SEL_LO] == 2'b00);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg      <= '{len_log: 2'd0, full: 1'b0, order: ORD_SEQ, wr_single: 1'b0};
      cas_lat  <= 2'd2;
      mode_err <= 1'b0;
    end else if (load_accept) begin
      if (len_code_ok(len_code)) begin
        cfg.len_log <= len_code[1:0];
        cfg.full    <= len_code[2];
        mode_err    <= 1'b0;
      end else begin
        mode_err    <= 1'b1;
      end
      cfg.order     <= beat_order_e'(operand[3]);
      cfg.wr_single <= operand[9];
      if (lat_code_ok(lat_code)) cas_lat <= lat_code[1:0];
    end
  end

endmodule

// File: rtl/colgen_seq.sv
module colgen_seq
  import colgen_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  burst_cfg_t       cfg,
  input  logic             start,
  input  logic             start_wr,
  input  logic [COL_W-1:0] start_col,
  input  logic             stop,
  output logic [COL_W-1:0] col,
  output logic             valid,
  output logic             last,
  output logic             burst_end
);

  function automatic logic [COL_W-1:0] blk_mask(input logic [1:0] len_log);
    return (COL_W'(1) << len_log) - COL_W'(1);
  endfunction

  function automatic logic [COL_W-1:0] beat_col(
    input logic [COL_W-1:0] base,
    input logic [COL_W-1:0] idx,
    input logic [1:0]       len_log,
    input beat_order_e      order,
    input logic             full
  );
    logic [COL_W-1:0] m;
    m = blk_mask(len_log);
    if (full)                return base + idx;
    else if (order == ORD_XOR) return base ^ (idx & m);
    else                     return (base & ~m) | ((base + idx) & m);
  endfunction

  logic             active_q;
  logic [COL_W-1:0] base_q;
  logic [COL_W-1:0] idx_q;
  logic [1:0]       len_log_q;
  logic             full_q;
  beat_order_e      order_q;
  logic             one_beat;

  assign one_beat  = start_wr && cfg.wr_single;
  assign col       = beat_col(base_q, idx_q, len_log_q, order_q, full_q);
  assign valid     = active_q;
  assign last      = active_q && !full_q && (idx_q == blk_mask(len_log_q));
  assign burst_end = active_q && !start && (stop || last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q  <= 1'b0;
      base_q    <= '0;
      idx_q     <= '0;
      len_log_q <= 2'd0;
      full_q    <= 1'b0;
      order_q   <= ORD_SEQ;
    end else if (start) begin
      active_q  <= 1'b1;
      base_q    <= start_col;
      idx_q     <= '0;
      len_log_q <= one_beat ? 2'd0 : cfg.len_log;
      full_q    <= one_beat ? 1'b0 : cfg.full;
      order_q   <= cfg.order;
    end else if (burst_end) begin
      active_q  <= 1'b0;
    end else if (active_q) begin
      idx_q     <= idx_q + COL_W'(1);
    end
  end

endmodule

// File: rtl/burst_colgen.sv
module burst_colgen
  import colgen_pkg::*;
#(
  parameter int COL_W = 8,
  parameter int OP_W  = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_load,
  input  logic [OP_W-1:0]  mode_operand,
  input  logic             start,
  input  logic             start_is_write,
  input  logic [COL_W-1:0] start_col,
  input  logic             stop,
  output logic [COL_W-1:0] col,
  output logic             beat_valid,
  output logic             last_beat,
  output logic [1:0]       cas_lat,
  output logic             mode_err
);

  burst_cfg_t cfg;
  logic       load_accept;
  logic       burst_end;

  colgen_modereg #(.OP_W(OP_W)) u_modereg (
    .clk         (clk),
    .rst_n       (rst_n),
    .load        (mode_load),
    .operand     (mode_operand),
    .cfg         (cfg),
    .cas_lat     (cas_lat),
    .mode_err    (mode_err),
    .load_accept (load_accept)
  );

  colgen_seq #(.COL_W(COL_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg       (cfg),
    .start     (start),
    .start_wr  (start_is_write),
    .start_col (start_col),
    .stop      (stop),
    .col       (col),
    .valid     (beat_valid),
    .last      (last_beat),
    .burst_end (burst_end)
  );

endmodule

// File: rtl/colgen_chk.sv
module colgen_chk #(
  parameter int COL_W = 8,
  parameter int OP_W  = 14
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mode_load,
  input logic [OP_W-1:0]  mode_operand,
  input logic             load_accept,
  input logic             start,
  input logic [COL_W-1:0] start_col,
  input logic             stop,
  input logic [COL_W-1:0] col,
  input logic             beat_valid,
  input logic             last_beat,
  input logic [1:0]       cas_lat,
  input logic             mode_err
);

  assert_start_shows_col_R8: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (beat_valid && col == $past(start_col)));

  assert_stop_ends_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && !start) |=> !beat_valid);

  assert_last_in_burst_R13: assert property (@(posedge clk) disable iff (!rst_n)
    last_beat |-> beat_valid);

  assert_last_then_idle_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (last_beat && !start) |=> !beat_valid);

  assert_reserved_len_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (load_accept && mode_operand[2] && (mode_operand[1:0] != 2'b11)) |=> mode_err);

  assert_other_reg_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_load && (mode_operand[OP_W-1:OP_W-2] != 2'b00)) |=> ($stable(cas_lat) && $stable(mode_err)));

  assert_lat_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cas_lat != 2'd0);

endmodule

bind burst_colgen colgen_chk #(.COL_W(COL_W), .OP_W(OP_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .mode_load    (mode_load),
  .mode_operand (mode_operand),
  .load_accept  (load_accept),
  .start        (start),
  .start_col    (start_col),
  .stop         (stop),
  .col          (col),
  .beat_valid   (beat_valid),
  .last_beat    (last_beat),
  .cas_lat      (cas_lat),
  .mode_err     (mode_err)
);

// File: tb/burst_colgen_bench.sv
module burst_colgen_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_load = 1'b0;
  logic [13:0] mode_operand = '0;
  logic        start = 1'b0;
  logic        start_is_write = 1'b0;
  logic [7:0]  start_col = '0;
  logic        stop = 1'b0;
  logic [7:0]  col;
  logic        beat_valid;
  logic        last_beat;
  logic [1:0]  cas_lat;
  logic        mode_err;

  int errors = 0;
  int checks = 0;
  string cur_req = "R1";

  // reference model state
  int m_len = 1;        // 1,2,4,8 or 256 (full page)
  int m_intl = 0;
  int m_ws = 0;
  int m_cl = 2;
  int m_err = 0;
  int m_full_on = 0;
  int m_full_col = 0;
  int q[$];

  always #2 clk = ~clk;

  burst_colgen u_burst_colgen (
    .clk(clk), .rst_n(rst_n), .mode_load(mode_load), .mode_operand(mode_operand),
    .start(start), .start_is_write(start_is_write), .start_col(start_col), .stop(stop),
    .col(col), .beat_valid(beat_valid), .last_beat(last_beat), .cas_lat(cas_lat),
    .mode_err(mode_err)
  );

  always @(posedge clk) begin
    if (rst_n) begin
      if (start) begin
        int len;
        q.delete();
        m_full_on = 0;
        len = (start_is_write && m_ws != 0) ? 1 : m_len;
        if (len == 256) begin
          m_full_on = 1;
          m_full_col = start_col;
        end else begin
          for (int i = 0; i < len; i++) begin
            int b;
            b = start_col;
            if (m_intl != 0) q.push_back(b ^ i);
            else q.push_back(b - (b % len) + ((b % len) + i) % len);
          end
        end
      end else if (stop) begin
        q.delete();
        m_full_on = 0;
      end else if (m_full_on != 0) begin
        m_full_col = (m_full_col + 1) % 256;
      end else if (q.size() > 0) begin
        void'(q.pop_front());
      end
      if (mode_load && mode_operand[13:12] == 2'b00) begin
        int lc, cc;
        lc = mode_operand[2:0];
        cc = mode_operand[6:4];
        if (lc <= 3) begin m_len = 1 << lc; m_err = 0; end
        else if (lc == 7) begin m_len = 256; m_err = 0; end
        else m_err = 1;
        m_intl = mode_operand[3];
        m_ws = mode_operand[9];
        if (cc >= 1 && cc <= 3) m_cl = cc;
      end
    end
  end

  task automatic check(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  task automatic compare();
    int ev, ec, el;
    ev = (m_full_on != 0 || q.size() > 0) ? 1 : 0;
    ec = (m_full_on != 0) ? m_full_col : (q.size() > 0 ? q[0] : 0);
    el = (m_full_on == 0 && q.size() == 1) ? 1 : 0;
    check("beat_valid", beat_valid, ev);
    if (ev != 0) begin
      check("col", col, ec);
      check("last_beat", last_beat, el);
    end else begin
      check("last_beat idle", last_beat, 0);
    end
    check("mode_err", mode_err, m_err);
    check("cas_lat", cas_lat, m_cl);
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
    compare();
    mode_load = 1'b0;
    start = 1'b0;
    stop = 1'b0;
    start_is_write = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic load(input logic [13:0] op);
    mode_load = 1'b1;
    mode_operand = op;
    cyc();
  endtask

  task automatic burst(input logic [7:0] c, input logic wr, input int n);
    start = 1'b1;
    start_col = c;
    start_is_write = wr;
    cyc();
    idle(n);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired at %0t", $time);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cur_req = "R1";
    compare();
    idle(2);

    cur_req = "R2"; // length codes 0..3 with sequential order
    load(14'h020); burst(8'h33, 1'b0, 2);
    load(14'h021); burst(8'h07, 1'b0, 3);
    load(14'h023); burst(8'h0D, 1'b0, 9);

    cur_req = "R3"; // sequential wrap: 1,2,3,0
    load(14'h022); burst(8'h01, 1'b0, 5); burst(8'h46, 1'b1, 5);

    cur_req = "R4"; // interleave: 5,4,7,6,1,0,3,2
    load(14'h02B); burst(8'h05, 1'b0, 9);
    load(14'h02A); burst(8'hF2, 1'b0, 4);

    cur_req = "R5"; // single-beat writes
    load(14'h223); burst(8'h14, 1'b1, 3); burst(8'h14, 1'b0, 9);

    cur_req = "R6"; // full page wraps past 255
    load(14'h027); burst(8'hFE, 1'b0, 300);

    cur_req = "R7"; // stop ends full page and fixed bursts
    stop = 1'b1; cyc(); idle(2);
    load(14'h023); burst(8'h20, 1'b0, 2);
    stop = 1'b1; cyc(); idle(3);

    cur_req = "R8"; // start every clock, start beats stop
    for (int i = 0; i < 6; i++) begin
      start = 1'b1; start_col = 8'(8'h10 + 3 * i); cyc();
    end
    start = 1'b1; stop = 1'b1; start_col = 8'h55; cyc(); idle(9);

    cur_req = "R9"; // reserved length code
    load(14'h024); burst(8'h09, 1'b0, 9);
    load(14'h026); burst(8'h0A, 1'b0, 9);
    load(14'h022); burst(8'h0B, 1'b0, 5);

    cur_req = "R10"; // latency field
    load(14'h032); idle(1); load(14'h012); idle(1);
    load(14'h072); idle(1); load(14'h002); idle(1); load(14'h032); idle(1);

    cur_req = "R11"; // other register selects ignored
    load(14'h1021); load(14'h2257); load(14'h3004);
    burst(8'h3F, 1'b1, 5);

    cur_req = "R12"; // load during a burst
    load(14'h023); start = 1'b1; start_col = 8'h62; cyc();
    idle(2); load(14'h029); idle(8);
    burst(8'h62, 1'b0, 3);

    cur_req = "R13"; // last beat then idle, and back-to-back at last
    load(14'h022); burst(8'h80, 1'b0, 3);
    start = 1'b1; start_col = 8'h90; cyc(); idle(5);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule